// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block sits between the dispatch stage and the register file of an out-of-order core. Each dispatched instruction claims one slot in a circular buffer of `DEPTH` slots. The slot number is handed back as the instruction's tag. Execution units may finish in any order. They return results on a writeback port keyed by that tag, and each result waits inside its own slot.

Only the oldest slot may leave, and only once its result is present and no fault was flagged for it. Leaving means the destination register and the value are presented to the register file. Everything younger waits behind the head, however early it finished.

Occupancy is the difference of the two pointers taken modulo twice the depth. Each pointer carries an extra wrap bit so that a full buffer and an empty one can be told apart.

Top module: `rob_inorder`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `occupancy` is 0 and `cmt_retire` is 0.
- R2: While the buffer is not full, a dispatch request is acknowledged in the same cycle. `disp_tag` gives the slot index allocated, and successive allocations take consecutive slot indices.
- R3: After `DEPTH` unretired allocations, `full` is 1 and `occupancy` equals `DEPTH`. A dispatch request while full gets `disp_ack`=0 and leaves `occupancy` unchanged.
- R4: A writeback carrying the head's tag makes the head eligible from the next cycle. `cmt_rd` then shows the head's destination register and `cmt_data` the written value, while `cmt_retire` is 1.
- R5: Entries retire strictly in allocation order. A completed younger entry never retires while an older one is still pending.
- R6: A head whose register-write enable was 0 at dispatch still retires (`cmt_retire`=1), with `cmt_we`=0.
- R7: A writeback with `wb_exc`=1 marks the entry as faulted. A faulted head never retires, and `occupancy` stays constant.
- R8: When an allocation and a retirement occur in the same cycle, `occupancy` is unchanged after the edge.
- R9: `occupancy` equals (write pointer − read pointer) modulo 2·`DEPTH`. After slot `DEPTH`-1 the next allocation receives tag 0.
- R10: A writeback whose tag names a free slot is ignored. When that slot is allocated later, it does not retire until it receives its own writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_req | input | 1 | Dispatch wants a slot |
| disp_rd | input | RAW | Destination register of the dispatched instruction |
| disp_we | input | 1 | Instruction writes a register |
| disp_ack | output | 1 | Slot granted this cycle |
| disp_tag | output | AW | Index of the granted slot |
| wb_valid | input | 1 | Result arriving |
| wb_tag | input | AW | Slot the result belongs to |
| wb_data | input | DW | Result value |
| wb_exc | input | 1 | Result carries a fault |
| cmt_retire | output | 1 | Head slot leaves this cycle |
| cmt_we | output | 1 | Register file write strobe |
| cmt_rd | output | RAW | Register to write |
| cmt_data | output | DW | Value to write |
| full | output | 1 | No free slot |
| empty | output | 1 | No occupied slot |
| occupancy | output | AW+1 | Number of occupied slots |

## Verification
Allocation at the tail and retirement at the head can fall in the same cycle. The bench provokes this once the buffer has just dropped from full to one free slot, by driving a dispatch request in the same cycle as the completed head retires. It judges the case by `disp_ack` and `cmt_retire` both being 1 in that cycle, and by `occupancy` being the same one cycle later. The opposite collision is also driven: a dispatch request while full, with the head retiring. There the request must be refused even though a slot is being freed at that edge.

// File: rtl/rob_pkg.sv
package rob_pkg;
   // Per-slot status bits
   typedef struct packed {
      logic valid;   // slot holds a live instruction
      logic done;    // result has arrived
      logic exc;     // result arrived with a fault
      logic we;      // instruction writes a register
   } rob_flags_t;
endpackage

// File: rtl/rob_ptr.sv
// Wrapping pointer with an extra lap bit.
module rob_ptr #(
   parameter int AW = 5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        inc,
   output logic [AW:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= '0;
      else if (inc) ptr <= ptr + 1'b1;
   end
endmodule

// File: rtl/rob_store.sv
// Slot storage: flags, destination and result for every slot.
module rob_store
   import rob_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int AW    = 5,
   parameter int RAW   = 5,
   parameter int DW    = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           alloc,
   input  logic [AW-1:0]  alloc_idx,
   input  logic [RAW-1:0] alloc_rd,
   input  logic           alloc_we,
   input  logic           wb_valid,
   input  logic [AW-1:0]  wb_tag,
   input  logic [DW-1:0]  wb_data,
   input  logic           wb_exc,
   input  logic           retire,
   input  logic [AW-1:0]  head_idx,
   output logic           head_ready,
   output logic           head_we,
   output logic [RAW-1:0] head_rd,
   output logic [DW-1:0]  head_data
);
   rob_flags_t     fl_q  [DEPTH];
   logic [RAW-1:0] rd_q  [DEPTH];
   logic [DW-1:0]  dat_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) fl_q[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (alloc && alloc_idx == AW'(i)) begin
               fl_q[i].valid <= 1'b1;
               fl_q[i].done  <= 1'b0;
               fl_q[i].exc   <= 1'b0;
               fl_q[i].we    <= alloc_we;
            end else begin
               if (retire && head_idx == AW'(i)) fl_q[i].valid <= 1'b0;
               if (wb_valid && wb_tag == AW'(i) && fl_q[i].valid) begin
                  fl_q[i].done <= 1'b1;
                  fl_q[i].exc  <= wb_exc;
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (alloc && alloc_idx == AW'(i)) rd_q[i] <= alloc_rd;
         if (wb_valid && wb_tag == AW'(i) && fl_q[i].valid) dat_q[i] <= wb_data;
      end
   end

   assign head_ready = fl_q[head_idx].valid && fl_q[head_idx].done && !fl_q[head_idx].exc;
   assign head_we    = fl_q[head_idx].we;
   assign head_rd    = rd_q[head_idx];
   assign head_data  = dat_q[head_idx];

   // R3: allocation never lands on a live slot
   assert_alloc_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !fl_q[alloc_idx].valid);
   // R7: a faulted head is never released
   assert_exc_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      retire |-> !fl_q[head_idx].exc);
endmodule

// File: rtl/rob_inorder.sv
module rob_inorder #(
   parameter int DEPTH = 32,
   parameter int RAW   = 5,
   parameter int DW    = 32,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           disp_req,
   input  logic [RAW-1:0] disp_rd,
   input  logic           disp_we,
   output logic           disp_ack,
   output logic [AW-1:0]  disp_tag,
   input  logic           wb_valid,
   input  logic [AW-1:0]  wb_tag,
   input  logic [DW-1:0]  wb_data,
   input  logic           wb_exc,
   output logic           cmt_retire,
   output logic           cmt_we,
   output logic [RAW-1:0] cmt_rd,
   output logic [DW-1:0]  cmt_data,
   output logic           full,
   output logic           empty,
   output logic [AW:0]    occupancy
);
   generate
      if (DEPTH < 2 || DEPTH != (1 << AW)) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (RAW < 1 || DW < 1) begin : g_bad_width
         $error("RAW and DW must be positive");
      end
   endgenerate

   logic [AW:0] wp, rp;
   logic        head_ready, head_we;

   rob_ptr #(.AW(AW)) u_wp (.clk(clk), .rst_n(rst_n), .inc(disp_ack),   .ptr(wp));
   rob_ptr #(.AW(AW)) u_rp (.clk(clk), .rst_n(rst_n), .inc(cmt_retire), .ptr(rp));

   assign empty     = (wp == rp);
   assign full      = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign occupancy = wp - rp;
   assign disp_ack  = disp_req && !full;
   assign disp_tag  = wp[AW-1:0];

   rob_store #(.DEPTH(DEPTH), .AW(AW), .RAW(RAW), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .alloc(disp_ack), .alloc_idx(wp[AW-1:0]), .alloc_rd(disp_rd), .alloc_we(disp_we),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data), .wb_exc(wb_exc),
      .retire(cmt_retire), .head_idx(rp[AW-1:0]),
      .head_ready(head_ready), .head_we(head_we), .head_rd(cmt_rd), .head_data(cmt_data)
   );

   assign cmt_retire = head_ready;
   assign cmt_we     = head_ready && head_we;

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !disp_ack);
   assert_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_req && !full) |=> (occupancy != 0));
   assert_empty_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !cmt_retire);
   assert_we_only_on_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_we |-> cmt_retire);
   assert_balance_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_ack && cmt_retire) |=> $stable(occupancy));
   assert_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy <= (AW+1)'(DEPTH));
   assert_head_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cmt_retire |=> (rp == $past(rp)));
endmodule

// File: tb/sim_rob_inorder.sv
`timescale 1ns/1ps
module sim_rob_inorder;
   localparam int DEPTH = 32, RAW = 5, DW = 32, AW = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic disp_req = 0, disp_we = 0, wb_valid = 0, wb_exc = 0;
   logic [RAW-1:0] disp_rd = '0;
   logic [AW-1:0]  wb_tag = '0;
   logic [DW-1:0]  wb_data = '0;
   logic disp_ack, cmt_retire, cmt_we, full, empty;
   logic [AW-1:0]  disp_tag;
   logic [RAW-1:0] cmt_rd;
   logic [DW-1:0]  cmt_data;
   logic [AW:0]    occupancy;

   always #2.5 clk = ~clk;

   rob_inorder u0 (.*);

   int n_run = 0, n_fail = 0;
   // bench model of expected commit order
   logic [RAW-1:0] m_rd [DEPTH];
   logic [DW-1:0]  m_dat[DEPTH];
   logic           m_we [DEPTH];
   int             m_head = 0;
   // sampled outputs
   logic s_ack, s_ret, s_we, s_full, s_empty;
   logic [AW-1:0] s_tag;
   logic [RAW-1:0] s_rd;
   logic [DW-1:0] s_dat;
   logic [AW:0] s_occ;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one clock: drive at negedge, sample after settling, then let the edge happen
   task automatic step(input logic dq, input logic [RAW-1:0] drd, input logic dwe,
                       input logic wv, input logic [AW-1:0] wt, input logic [DW-1:0] wd,
                       input logic we_x);
      @(negedge clk);
      disp_req = dq; disp_rd = drd; disp_we = dwe;
      wb_valid = wv; wb_tag = wt; wb_data = wd; wb_exc = we_x;
      #1;
      s_ack = disp_ack; s_tag = disp_tag; s_ret = cmt_retire; s_we = cmt_we;
      s_rd = cmt_rd; s_dat = cmt_data; s_full = full; s_empty = empty; s_occ = occupancy;
      if (s_ack) begin m_rd[s_tag] = drd; m_we[s_tag] = dwe; end
      if (wv) m_dat[wt] = wd;
      if (s_ret) begin // R5: in-order release against the bench model
         check("R5 order rd", 32'(s_rd), 32'(m_rd[m_head % DEPTH]));
         check("R5 order data", s_dat, m_dat[m_head % DEPTH]);
         check("R6 we", 32'(s_we), 32'(m_we[m_head % DEPTH]));
         m_head++;
      end
   endtask

   task automatic idle();
      step(0, '0, 0, 0, '0, '0, 0);
   endtask

   task automatic t_reset();
      @(negedge clk); #1;
      check("R1 empty", 32'(empty), 1);
      check("R1 full", 32'(full), 0);
      check("R1 occupancy", 32'(occupancy), 0);
      check("R1 retire", 32'(cmt_retire), 0);
   endtask

   task automatic t_out_of_order();
      step(1, 5'd7, 1, 0, '0, '0, 0); check("R2 tag0", 32'(s_tag), 0); check("R2 ack", 32'(s_ack), 1);
      step(1, 5'd8, 1, 0, '0, '0, 0); check("R2 tag1", 32'(s_tag), 1);
      step(1, 5'd9, 0, 0, '0, '0, 0); check("R2 tag2", 32'(s_tag), 2);
      step(0, '0, 0, 1, 5'd2, 32'hC2, 0); check("R5 hold", 32'(s_ret), 0);
      step(0, '0, 0, 1, 5'd1, 32'hC1, 0); check("R5 hold", 32'(s_ret), 0);
      check("R9 occupancy", 32'(s_occ), 3);
      step(0, '0, 0, 1, 5'd0, 32'hC0, 0); check("R4 not yet", 32'(s_ret), 0);
      idle();
      check("R4 retire", 32'(s_ret), 1); check("R4 rd", 32'(s_rd), 7); check("R4 data", s_dat, 32'hC0);
      idle(); check("R5 second", 32'(s_dat), 32'hC1);
      idle(); check("R6 retire", 32'(s_ret), 1); check("R6 no write", 32'(s_we), 0);
      idle(); check("R1 empty again", 32'(s_empty), 1); check("R9 occ zero", 32'(s_occ), 0);
   endtask

   task automatic t_fill_and_collide();
      for (int k = 0; k < DEPTH; k++) begin
         step(1, 5'(k), 1, 0, '0, '0, 0);
         check("R9 wrap tag", 32'(s_tag), 32'((3 + k) % DEPTH));
      end
      idle();
      check("R3 full", 32'(s_full), 1); check("R3 occ", 32'(s_occ), DEPTH);
      step(1, 5'd1, 1, 0, '0, '0, 0); check("R3 refused", 32'(s_ack), 0);
      idle(); check("R3 occ kept", 32'(s_occ), DEPTH);
      step(0, '0, 0, 1, 5'd3, 32'h300, 0);
      step(1, 5'd2, 1, 0, '0, '0, 0);
      check("R3 refused during retire", 32'(s_ack), 0); check("R4 retire", 32'(s_ret), 1);
      step(0, '0, 0, 1, 5'd4, 32'h400, 0);
      check("R9 occ", 32'(s_occ), DEPTH - 1);
      step(1, 5'd3, 1, 0, '0, '0, 0);
      check("R8 ack", 32'(s_ack), 1); check("R8 retire", 32'(s_ret), 1);
      check("R9 wrap slot", 32'(s_tag), 3);
      idle(); check("R8 occ unchanged", 32'(s_occ), DEPTH - 1);
      for (int k = 0; k < DEPTH - 1; k++) step(0, '0, 0, 1, 5'((5 + k) % DEPTH), 32'(32'h1000 + k), 0);
      for (int k = 0; k < 4; k++) idle();
      check("R1 drained", 32'(s_empty), 1);
      check("R5 retire count", 32'(m_head), 3 + DEPTH + 1);
   endtask

   task automatic t_stale_writeback();
      step(0, '0, 0, 1, 5'd4, 32'hBAD, 0);   // slot 4 is free
      step(1, 5'd11, 1, 0, '0, '0, 0); check("R10 tag", 32'(s_tag), 4);
      idle(); check("R10 ignored", 32'(s_ret), 0);
      idle(); check("R10 ignored", 32'(s_ret), 0);
      step(0, '0, 0, 1, 5'd4, 32'h44, 0);
      idle(); check("R10 real wb", 32'(s_ret), 1); check("R10 data", s_dat, 32'h44);
   endtask

   task automatic t_fault();
      step(1, 5'd12, 1, 0, '0, '0, 0); check("R7 tag", 32'(s_tag), 5);
      step(0, '0, 0, 1, 5'd5, 32'h55, 1);
      for (int k = 0; k < 3; k++) begin
         idle(); check("R7 blocked", 32'(s_ret), 0);
      end
      check("R7 occ", 32'(s_occ), 1);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_out_of_order();
      t_fill_and_collide();
      t_stale_writeback();
      t_fault();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule